// File: doc/BRIEF.md
# Digital Servo-Loop Code-Edge Tracker

This block measures where an ADC output crosses from a chosen code to the next code. It keeps a digital stimulus register and shows it to a DAC, and the DAC drives the ADC under test. Each time an ADC code comes back, the block compares it with the target code. If the code is above the target, the stimulus moves down by a fixed step. Otherwise it moves up by the same step. Once the stimulus is close to the edge, it flips between the two sides on every loop cycle and traces a small triangle around the transition level.

The block treats the first change of step direction as the sign that the loop has settled. It then discards a programmable number of further loop cycles. After that it adds up a power-of-two count of stimulus values. The sum is the mean stimulus, with the window's log2 as fraction bits, so the estimate resolves finer than one step. After each DAC update a programmable guard time passes before an ADC code is accepted. This lets disturbances at the converter input, such as kickback, die out first. The stimulus saturates at both ends of the DAC range, and a flag records that it did.

Software or a test sequencer sets the configuration and pulses start. It then waits for the done flag and reads the result. The result and the flag stay unchanged until the next start.

Top module: `servo_edge_tracker`

## Requirements
- R1: A start pulse loads the stimulus from `cfg_init`, so `dac_code` equals that value in the next cycle. The same pulse captures target, step, guard and settle values. Changes to the configuration inputs without a start have no effect on a run in progress.
- R2: When an accepted ADC code is greater than the target, the next stimulus is the current one minus the step, clamped at 0.
- R3: When an accepted ADC code is less than or equal to the target, the next stimulus is the current one plus the step, clamped at 2^DAC_W-1.
- R4: Any clamp during a run sets `res_sat`. The flag stays set until the next start, which clears it.
- R5: Each stimulus value is announced by `dac_stb` high for exactly one cycle. The first strobe comes in the cycle after start, and there is one strobe per loop update.
- R6: `adc_valid` is ignored in the strobe cycle and in the `cfg_guard` cycles after it. After that the block waits, for as long as needed, for the next `adc_valid`.
- R7: No stimulus value counts toward the result until the step direction has reversed once. After the reversal update, `cfg_settle` further updates are discarded.
- R8: The next 2^AVG_K updated stimulus values after settling are summed. `res_value` is that sum, which is the mean stimulus in fixed point with AVG_K fraction bits. `res_done` rises after the last of them.
- R9: While `res_done` is high, `res_value`, `res_done` and `dac_code` hold. No strobe is issued, and `adc_valid` has no effect.
- R10: A start during a run abandons that run and begins a new one with the new configuration.
- R11: After reset, `dac_code`, `dac_stb`, `res_value`, `res_done` and `res_sat` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Start pulse; captures configuration and begins a run |
| cfg_init | input | DAC_W | Initial stimulus value |
| cfg_step | input | STEP_W | Step size for both directions |
| cfg_target | input | ADC_W | Target ADC code whose upper edge is tracked |
| cfg_guard | input | GUARD_W | Cycles after a strobe during which ADC codes are ignored |
| cfg_settle | input | SETTLE_W | Updates discarded after the first direction reversal |
| dac_code | output | DAC_W | Current stimulus value to the DAC |
| dac_stb | output | 1 | One-cycle strobe marking a new stimulus value |
| adc_code | input | ADC_W | Code returned by the ADC under test |
| adc_valid | input | 1 | Marks `adc_code` as valid |
| res_value | output | DAC_W+AVG_K | Sum of the averaging window (mean with AVG_K fraction bits) |
| res_done | output | 1 | Result ready; held until next start |
| res_sat | output | 1 | Stimulus clamped at least once during the run |

## Verification
Several properties are checked on every cycle by assertions:
- the stimulus moves in the direction the compared code demands;
- a strobe lasts only one cycle;
- no code is accepted before the guard time has run;
- the saturation flag only rises at a range end and then stays set;
- averaging never begins before a reversal;
- the result stays frozen while done.

Only the bench's closed-loop scenarios can show that the exact sequence of stimulus values and the final sum match an independent model. That includes starts from below and from above the edge, both clamp directions, a restart in the middle of a run, and configuration changes without a start.

// File: rtl/servo_pkg.sv
package servo_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_ISSUE,
      SQ_GUARD,
      SQ_LISTEN,
      SQ_DONE
   } sq_state_e;

   typedef enum logic [1:0] {
      PH_TRACK,
      PH_SKIP,
      PH_AVG
   } ph_e;

endpackage

// File: rtl/servo_step_unit.sv
module servo_step_unit #(
   parameter int DAC_W  = 10,
   parameter int STEP_W = 10
) (
   input  logic [DAC_W-1:0]  cur,
   input  logic [STEP_W-1:0] step,
   input  logic              go_down,
   output logic [DAC_W-1:0]  nxt,
   output logic              clamped
);

   localparam int EXT_W = DAC_W + 1;
   localparam logic [EXT_W-1:0] FULL = {1'b0, {DAC_W{1'b1}}};

   logic [EXT_W-1:0] step_ext;
   logic [EXT_W-1:0] cur_ext;
   logic [EXT_W-1:0] up_val;
   logic [EXT_W-1:0] dn_val;

   generate
      if (STEP_W > DAC_W) begin : g_bad_step
         $error("servo_step_unit: STEP_W must not exceed DAC_W");
      end
      if (STEP_W == DAC_W) begin : g_step_full
         assign step_ext = {1'b0, step};
      end else begin : g_step_narrow
         assign step_ext = {{(EXT_W - STEP_W){1'b0}}, step};
      end
   endgenerate

   assign cur_ext = {1'b0, cur};
   assign up_val  = cur_ext + step_ext;
   assign dn_val  = cur_ext - step_ext;

   always_comb begin
      nxt     = cur;
      clamped = 1'b0;
      if (go_down) begin
         if (step_ext > cur_ext) begin
            nxt     = '0;
            clamped = 1'b1;
         end else begin
            nxt = dn_val[DAC_W-1:0];
         end
      end else begin
         if (up_val > FULL) begin
            nxt     = FULL[DAC_W-1:0];
            clamped = 1'b1;
         end else begin
            nxt = up_val[DAC_W-1:0];
         end
      end
   end

endmodule

// File: rtl/servo_seq.sv
module servo_seq
   import servo_pkg::*;
#(
   parameter int GUARD_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [GUARD_W-1:0] guard,
   input  logic               adc_valid,
   input  logic               last,
   output logic               issue,
   output logic               upd,
   output logic               done
);

   sq_state_e          state_q;
   logic [GUARD_W-1:0] gcnt_q;

   generate
      if (GUARD_W < 1) begin : g_bad_guard
         $error("servo_seq: GUARD_W must be at least 1");
      end
   endgenerate

   assign issue = (state_q == SQ_ISSUE);
   assign done  = (state_q == SQ_DONE);
   assign upd   = (state_q == SQ_LISTEN) && adc_valid && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         gcnt_q  <= '0;
      end else if (start) begin
         state_q <= SQ_ISSUE;
         gcnt_q  <= '0;
      end else begin
         case (state_q)
            SQ_ISSUE: begin
               if (guard == '0) begin
                  state_q <= SQ_LISTEN;
               end else begin
                  state_q <= SQ_GUARD;
                  gcnt_q  <= GUARD_W'(1);
               end
            end
            SQ_GUARD: begin
               if (gcnt_q == guard) state_q <= SQ_LISTEN;
               else                 gcnt_q  <= gcnt_q + GUARD_W'(1);
            end
            SQ_LISTEN: begin
               if (adc_valid) state_q <= last ? SQ_DONE : SQ_ISSUE;
            end
            default: state_q <= state_q;
         endcase
      end
   end

   // R5
   issue_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !start) |=> !issue);

   // R9
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

endmodule

// File: rtl/servo_phase_ctrl.sv
module servo_phase_ctrl
   import servo_pkg::*;
#(
   parameter int SETTLE_W = 6,
   parameter int AVG_K    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                upd,
   input  logic                go_down,
   input  logic [SETTLE_W-1:0] settle,
   output logic                take,
   output logic                last
);

   localparam int CNT_W = SETTLE_W + 1;

   ph_e                 ph_q;
   logic                have_prev_q;
   logic                prev_down_q;
   logic [SETTLE_W-1:0] skip_q;
   logic [AVG_K-1:0]    avg_q;
   logic [CNT_W-1:0]    skip_inc;
   logic                reversal;

   generate
      if (AVG_K < 1) begin : g_bad_k
         $error("servo_phase_ctrl: AVG_K must be at least 1");
      end
      if (SETTLE_W < 1) begin : g_bad_settle
         $error("servo_phase_ctrl: SETTLE_W must be at least 1");
      end
   endgenerate

   assign skip_inc = {1'b0, skip_q} + CNT_W'(1);
   assign reversal = have_prev_q && (go_down != prev_down_q);
   assign take     = upd && (ph_q == PH_AVG);
   assign last     = (ph_q == PH_AVG) && (avg_q == {AVG_K{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q        <= PH_TRACK;
         have_prev_q <= 1'b0;
         prev_down_q <= 1'b0;
         skip_q      <= '0;
         avg_q       <= '0;
      end else if (start) begin
         ph_q        <= PH_TRACK;
         have_prev_q <= 1'b0;
         prev_down_q <= 1'b0;
         skip_q      <= '0;
         avg_q       <= '0;
      end else if (upd) begin
         prev_down_q <= go_down;
         have_prev_q <= 1'b1;
         case (ph_q)
            PH_TRACK: begin
               if (reversal) begin
                  skip_q <= '0;
                  ph_q   <= (settle == '0) ? PH_AVG : PH_SKIP;
               end
            end
            PH_SKIP: begin
               skip_q <= skip_inc[SETTLE_W-1:0];
               if (skip_inc == {1'b0, settle}) ph_q <= PH_AVG;
            end
            default: avg_q <= avg_q + AVG_K'(1);
         endcase
      end
   end

   // R7
   no_early_avg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> have_prev_q);

endmodule

// File: rtl/servo_avg_unit.sv
module servo_avg_unit #(
   parameter int DAC_W = 10,
   parameter int AVG_K = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic                   take,
   input  logic [DAC_W-1:0]       sample,
   output logic [DAC_W+AVG_K-1:0] sum
);

   localparam int RES_W = DAC_W + AVG_K;

   logic [RES_W-1:0] sum_q;
   logic [RES_W-1:0] sample_ext;

   generate
      if (DAC_W < 2) begin : g_bad_w
         $error("servo_avg_unit: DAC_W must be at least 2");
      end
   endgenerate

   assign sample_ext = {{AVG_K{1'b0}}, sample};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sum_q <= '0;
      else if (clear) sum_q <= '0;
      else if (take)  sum_q <= sum_q + sample_ext;
   end

   assign sum = sum_q;

endmodule

// File: rtl/servo_edge_tracker.sv
module servo_edge_tracker
   import servo_pkg::*;
#(
   parameter int DAC_W    = 10,
   parameter int ADC_W    = 8,
   parameter int STEP_W   = 10,
   parameter int GUARD_W  = 4,
   parameter int SETTLE_W = 6,
   parameter int AVG_K    = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_start,
   input  logic [DAC_W-1:0]       cfg_init,
   input  logic [STEP_W-1:0]      cfg_step,
   input  logic [ADC_W-1:0]       cfg_target,
   input  logic [GUARD_W-1:0]     cfg_guard,
   input  logic [SETTLE_W-1:0]    cfg_settle,
   output logic [DAC_W-1:0]       dac_code,
   output logic                   dac_stb,
   input  logic [ADC_W-1:0]       adc_code,
   input  logic                   adc_valid,
   output logic [DAC_W+AVG_K-1:0] res_value,
   output logic                   res_done,
   output logic                   res_sat
);

   localparam int RES_W = DAC_W + AVG_K;
   localparam int SINCE_W = GUARD_W + 1;
   localparam logic [DAC_W-1:0] DAC_MAX = {DAC_W{1'b1}};

   generate
      if (ADC_W < 1 || ADC_W > DAC_W + 8) begin : g_bad_adc
         $error("servo_edge_tracker: ADC_W out of range");
      end
   endgenerate

   logic [DAC_W-1:0]    acc_q;
   logic [ADC_W-1:0]    tgt_q;
   logic [STEP_W-1:0]   step_q;
   logic [GUARD_W-1:0]  guard_q;
   logic [SETTLE_W-1:0] settle_q;
   logic                sat_q;

   logic                go_down;
   logic [DAC_W-1:0]    acc_nxt;
   logic                clamped;
   logic                upd;
   logic                take;
   logic                last;
   logic                issue;
   logic                done;
   logic [RES_W-1:0]    sum;

   assign go_down = (adc_code > tgt_q);

   servo_step_unit #(.DAC_W(DAC_W), .STEP_W(STEP_W)) u_step (
      .cur     (acc_q),
      .step    (step_q),
      .go_down (go_down),
      .nxt     (acc_nxt),
      .clamped (clamped)
   );

   servo_seq #(.GUARD_W(GUARD_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cfg_start),
      .guard     (guard_q),
      .adc_valid (adc_valid),
      .last      (last),
      .issue     (issue),
      .upd       (upd),
      .done      (done)
   );

   servo_phase_ctrl #(.SETTLE_W(SETTLE_W), .AVG_K(AVG_K)) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (cfg_start),
      .upd     (upd),
      .go_down (go_down),
      .settle  (settle_q),
      .take    (take),
      .last    (last)
   );

   servo_avg_unit #(.DAC_W(DAC_W), .AVG_K(AVG_K)) u_avg (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (cfg_start),
      .take   (take),
      .sample (acc_nxt),
      .sum    (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         tgt_q    <= '0;
         step_q   <= '0;
         guard_q  <= '0;
         settle_q <= '0;
         sat_q    <= 1'b0;
      end else if (cfg_start) begin
         acc_q    <= cfg_init;
         tgt_q    <= cfg_target;
         step_q   <= cfg_step;
         guard_q  <= cfg_guard;
         settle_q <= cfg_settle;
         sat_q    <= 1'b0;
      end else if (upd) begin
         acc_q <= acc_nxt;
         if (clamped) sat_q <= 1'b1;
      end
   end

   assign dac_code  = acc_q;
   assign dac_stb   = issue;
   assign res_value = sum;
   assign res_done  = done;
   assign res_sat   = sat_q;

   // Checker-side count of cycles since the last strobe (saturating).
   logic [SINCE_W-1:0] since_stb_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         since_stb_q <= '0;
      else if (dac_stb)                   since_stb_q <= SINCE_W'(1);
      else if (since_stb_q != '1 && since_stb_q != '0)
                                          since_stb_q <= since_stb_q + SINCE_W'(1);
   end

   // R1
   init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_start |=> (dac_code == $past(cfg_init)));

   // R2
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && go_down) |=> (dac_code <= $past(dac_code)));

   // R3
   step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !go_down) |=> (dac_code >= $past(dac_code)));

   // R4
   sat_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_sat) |-> (dac_code == '0 || dac_code == DAC_MAX));

   // R4
   sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_sat && !cfg_start) |=> res_sat);

   // R6
   guard_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> (since_stb_q > {1'b0, guard_q}));

   // R9
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_done && !cfg_start) |=> (res_done && $stable(res_value) && $stable(dac_code)));

   // R9
   no_stb_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |-> !dac_stb);

endmodule

// File: tb/tb_servo_edge_tracker.sv
module tb_servo_edge_tracker;

   localparam int DAC_W    = 10;
   localparam int ADC_W    = 8;
   localparam int STEP_W   = 10;
   localparam int GUARD_W  = 4;
   localparam int SETTLE_W = 6;
   localparam int AVG_K    = 4;
   localparam int RES_W    = DAC_W + AVG_K;
   localparam int DMAX     = (1 << DAC_W) - 1;
   localparam int AMAX     = (1 << ADC_W) - 1;
   localparam int SHIFT    = DAC_W - ADC_W;
   localparam int WIN      = 1 << AVG_K;

   typedef struct {
      int sum;
      int sat;
      int nupd;
   } res_exp_t;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                cfg_start = 1'b0;
   logic [DAC_W-1:0]    cfg_init = '0;
   logic [STEP_W-1:0]   cfg_step = '0;
   logic [ADC_W-1:0]    cfg_target = '0;
   logic [GUARD_W-1:0]  cfg_guard = '0;
   logic [SETTLE_W-1:0] cfg_settle = '0;
   logic [DAC_W-1:0]    dac_code;
   logic                dac_stb;
   logic [ADC_W-1:0]    adc_code;
   logic                adc_valid;
   logic [RES_W-1:0]    res_value;
   logic                res_done;
   logic                res_sat;

   logic                rsp_valid = 1'b0;
   logic [ADC_W-1:0]    rsp_drv = '0;
   logic                poke_valid = 1'b0;
   logic [ADC_W-1:0]    poke_code = '0;

   assign adc_valid = rsp_valid | poke_valid;
   assign adc_code  = poke_valid ? poke_code : rsp_drv;

   always #5 clk = ~clk;

   servo_edge_tracker #(
      .DAC_W(DAC_W), .ADC_W(ADC_W), .STEP_W(STEP_W),
      .GUARD_W(GUARD_W), .SETTLE_W(SETTLE_W), .AVG_K(AVG_K)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_init(cfg_init),
      .cfg_step(cfg_step), .cfg_target(cfg_target), .cfg_guard(cfg_guard),
      .cfg_settle(cfg_settle), .dac_code(dac_code), .dac_stb(dac_stb),
      .adc_code(adc_code), .adc_valid(adc_valid), .res_value(res_value),
      .res_done(res_done), .res_sat(res_sat)
   );

   int checks = 0;
   int fails = 0;
   int cur_guard = 0;
   int cur_delay = 0;
   int cur_off = 0;
   int cur_tgt = 0;
   int stb_cnt = 0;
   int run_base = 0;
   int res_seen = 0;
   int exp_dac[$];
   res_exp_t exp_res[$];

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic int adc_model(input int d);
      int v;
      v = (d + cur_off) >> SHIFT;
      if (v > AMAX) v = AMAX;
      return v;
   endfunction

   // Reference loop: pushes expected strobe values and the expected result.
   task automatic model_run(input int init, input int step, input int tgt,
                            input int settle, input bit push_res);
      int acc, nxt, code, n, ph, skip, avg, sum, sat;
      bit have, prev, down, fin;
      acc = init; n = 0; ph = 0; skip = 0; avg = 0; sum = 0; sat = 0;
      have = 0; prev = 0; fin = 0;
      exp_dac.push_back(acc);
      while (!fin && n < 5000) begin
         code = adc_model(acc);
         down = (code > tgt);
         if (down) begin
            if (acc < step) begin nxt = 0; sat = 1; end
            else nxt = acc - step;
         end else begin
            if (acc + step > DMAX) begin nxt = DMAX; sat = 1; end
            else nxt = acc + step;
         end
         n++;
         if (ph == 0) begin
            if (have && down != prev) begin
               if (settle == 0) ph = 2;
               else begin ph = 1; skip = 0; end
            end
         end else if (ph == 1) begin
            skip++;
            if (skip == settle) ph = 2;
         end else begin
            sum += nxt;
            avg++;
            if (avg == WIN) fin = 1;
         end
         prev = down; have = 1; acc = nxt;
         if (!fin) exp_dac.push_back(acc);
      end
      if (push_res) exp_res.push_back('{sum, sat, n});
   endtask

   // ADC responder: decoy codes during the guard window, optional extra delay,
   // then the true code for the latched stimulus.
   int  rsp_phase = 0;
   bit  rsp_active = 0;
   int  rsp_code = 0;
   always @(negedge clk) begin
      if (dac_stb) begin
         rsp_code   = adc_model(int'(dac_code));
         rsp_phase  = 0;
         rsp_active = 1;
      end else if (rsp_active) begin
         rsp_phase++;
      end
      if (rsp_active) begin
         if (rsp_phase <= cur_guard) begin
            rsp_valid = 1'b1;
            rsp_drv   = (rsp_code > cur_tgt) ? '0 : ADC_W'(AMAX);
         end else if (rsp_phase <= cur_guard + cur_delay) begin
            rsp_valid = 1'b0;
         end else if (rsp_phase == cur_guard + cur_delay + 1) begin
            rsp_valid = 1'b1;
            rsp_drv   = ADC_W'(rsp_code);
         end else begin
            rsp_valid  = 1'b0;
            rsp_active = 0;
         end
      end else begin
         rsp_valid = 1'b0;
      end
   end

   // Monitor: every strobe is compared against the expected stimulus queue.
   always @(negedge clk) begin
      if (rst_n && dac_stb) begin
         stb_cnt++;
         if (exp_dac.size() > 0) begin
            int e;
            e = exp_dac.pop_front();
            chk(int'(dac_code) == e, "R2 R3 stimulus value at strobe", dac_code, e);
         end else begin
            chk(1'b0, "R5 unexpected strobe", dac_code, -1);
         end
      end
   end

   // Monitor: results popped from the scoreboard on each rising done.
   bit done_prev = 0;
   always @(negedge clk) begin
      if (rst_n && res_done && !done_prev) begin
         if (exp_res.size() > 0) begin
            res_exp_t r;
            r = exp_res.pop_front();
            chk(int'(res_value) == r.sum, "R8 averaged sum", res_value, r.sum);
            chk(int'(res_sat) == r.sat, "R4 saturation flag", res_sat, r.sat);
            chk(stb_cnt - run_base == r.nupd, "R5 strobe count per run",
                stb_cnt - run_base, r.nupd);
         end else begin
            chk(1'b0, "R8 unexpected done", res_value, -1);
         end
         res_seen++;
      end
      done_prev = res_done;
   end

   task automatic launch(input int init, input int step, input int tgt, input int guard,
                         input int settle, input int delay, input int off, input bit push_res);
      cur_guard = guard; cur_delay = delay; cur_off = off; cur_tgt = tgt;
      model_run(init, step, tgt, settle, push_res);
      run_base   = stb_cnt;
      cfg_init   = DAC_W'(init);
      cfg_step   = STEP_W'(step);
      cfg_target = ADC_W'(tgt);
      cfg_guard  = GUARD_W'(guard);
      cfg_settle = SETTLE_W'(settle);
      cfg_start  = 1'b1;
      @(negedge clk);
      cfg_start  = 1'b0;
      chk(int'(dac_code) == init, "R1 stimulus loaded from init", dac_code, init);
   endtask

   task automatic wait_result();
      int want;
      want = res_seen + 1;
      while (res_seen < want) @(negedge clk);
      chk(exp_dac.size() == 0, "R5 all expected strobes seen", exp_dac.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [RES_W-1:0] held_res;
      logic [DAC_W-1:0] held_dac;
      int held_stb;

      repeat (3) @(negedge clk);
      // R11 reset state
      chk(dac_code == '0, "R11 dac_code reset", dac_code, 0);
      chk(dac_stb == 1'b0, "R11 dac_stb reset", dac_stb, 0);
      chk(res_value == '0, "R11 res_value reset", res_value, 0);
      chk(res_done == 1'b0, "R11 res_done reset", res_done, 0);
      chk(res_sat == 1'b0, "R11 res_sat reset", res_sat, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Descent from above, guard 2, settle 3 (R2, R6, R7, R8)
      launch(600, 8, 100, 2, 3, 0, 0, 1);
      wait_result();

      // R9: hold while done, decoy ADC codes have no effect
      held_res = res_value; held_dac = dac_code; held_stb = stb_cnt;
      for (int i = 0; i < 12; i++) begin
         poke_valid = 1'b1;
         poke_code  = (i % 2 == 0) ? '0 : ADC_W'(AMAX);
         @(negedge clk);
      end
      poke_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(res_done == 1'b1, "R9 done held", res_done, 1);
      chk(res_value == held_res, "R9 result held", res_value, held_res);
      chk(dac_code == held_dac, "R9 stimulus held", dac_code, held_dac);
      chk(stb_cnt == held_stb, "R9 no strobe while done", stb_cnt, held_stb);

      // Ascent from below with delayed ADC and config changes without start (R1, R3, R6)
      launch(40, 5, 100, 0, 0, 2, 1, 1);
      while (stb_cnt - run_base < 5) @(negedge clk);
      cfg_target = 8'd200; cfg_step = STEP_W'(1); cfg_guard = GUARD_W'(9);
      cfg_settle = SETTLE_W'(20); cfg_init = DAC_W'(7);
      wait_result();

      // Clamp at full scale (R3, R4)
      launch(1000, 50, 254, 1, 1, 0, 0, 1);
      wait_result();
      chk(res_sat == 1'b1, "R4 sat flag after top clamp", res_sat, 1);

      // Clamp at zero; start clears the previous sat flag first (R2, R4)
      launch(30, 40, 0, 3, 2, 1, 0, 1);
      wait_result();

      // Non-clamping run after a clamp: flag must be clear (R4)
      launch(300, 1, 74, 0, 0, 0, 0, 1);
      wait_result();
      chk(res_sat == 1'b0, "R4 sat flag cleared by start", res_sat, 0);

      // Restart in the middle of a run (R10)
      launch(900, 4, 50, 1, 1, 6, 0, 0);
      wait (stb_cnt - run_base >= 3);
      repeat (3) @(negedge clk);
      exp_dac.delete();
      launch(200, 7, 60, 1, 4, 0, 2, 1);
      wait_result();
      chk(res_done == 1'b1, "R10 restarted run completes", res_done, 1);

      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule